// File: doc/BRIEF.md
# Synchronous Binary Counter with Selectable Carry Style

This block is a synchronous binary up-counter with a synchronous, active-high reset and a terminal-count carry output. On every rising clock edge that is not a reset edge, the count moves to the next binary value. After the all-ones value it wraps to zero.

A single parameter selects how the carry is built. In the decoded style, carry is an AND of the stored count bits. It therefore settles one gate delay after the count flip-flops switch. In the registered style, carry has its own flip-flop that is loaded one state early. Carry then leaves a flip-flop on the same clock edge as the count bits, with no decode logic between the register and the pin. Both styles give the same count and carry values at every clock edge. The choice only trades one flip-flop against the clock-to-carry path.

Top module: `sync_carry_counter`

## Requirements
- R1: Outside reset, each rising clock edge advances count_o by exactly one, modulo 2^WIDTH (WIDTH defaults to 4).
- R2: Reset is synchronous and active high: an edge with rst_i high sets count_o to 0 and carry_o to 0, whatever the count was, including in the middle of a count sequence.
- R3: carry_o is 1 exactly when count_o is all ones (4'b1111 at the default width), and 0 for every other count.
- R4: From the all-ones count, the next non-reset edge gives count_o = 0, and carry_o falls on that same edge.
- R5: With CARRY_STYLE = CARRY_FLOPPED (the default), carry_o is the output of a dedicated flip-flop. Its input is high when the current count is all ones except bit 0 (4'b1110) and reset is low, so carry_o rises on the same edge that count_o becomes all ones.
- R6: With CARRY_STYLE = CARRY_DECODED, carry_o is the AND of the stored count bits and uses no extra flip-flop.
- R7: Given the same clock and reset sequence, both styles produce identical count_o and carry_o values after every clock edge.
- R8: WIDTH below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| count_o | output | WIDTH | Current count value |
| carry_o | output | 1 | High while the count is all ones |

## Verification
The hardest case to reach from the ports is a reset that lands on the edge where the carry flip-flop would otherwise load, or that lands mid-sequence and must not leave a stale carry. The stimulus reaches this in three steps. It first runs the counter through more than two full wraps. It then asserts reset at an arbitrary mid-count value, and later asserts reset exactly while the count is 4'b1110. A scoreboard compares both carry styles, instantiated side by side, against one independent model after every edge.

// File: rtl/sccnt_pkg.sv
package sccnt_pkg;

   typedef enum logic {
      CARRY_DECODED = 1'b0,
      CARRY_FLOPPED = 1'b1
   } carry_style_e;

   function automatic int unsigned min_width();
      return 2;
   endfunction

endpackage

// File: rtl/sccnt_core.sv
module sccnt_core #(
   parameter int WIDTH = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [WIDTH-1:0] cnt_q_o
);
   localparam logic [WIDTH-1:0] ZERO = '0;
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q + ONE;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) cnt_q <= ZERO;
      else       cnt_q <= cnt_d;
   end

   assign cnt_q_o = cnt_q;
endmodule

// File: rtl/sccnt_carry_dec.sv
module sccnt_carry_dec #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cnt_i,
   output logic             carry_o
);
   always_comb begin
      carry_o = &cnt_i;
   end
endmodule

// File: rtl/sccnt_carry_reg.sv
module sccnt_carry_reg #(
   parameter int WIDTH = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] cnt_i,
   output logic             carry_o
);
   // one state ahead of terminal count: all ones except bit 0
   localparam logic [WIDTH-1:0] PRE_TERM = {{(WIDTH-1){1'b1}}, 1'b0};

   logic carry_q;
   logic carry_d;

   always_comb begin
      carry_d = (cnt_i == PRE_TERM) && !rst_i;
   end

   always_ff @(posedge clk_i) begin
      carry_q <= carry_d;
   end

   assign carry_o = carry_q;
endmodule

// File: rtl/sync_carry_counter.sv
module sync_carry_counter
   import sccnt_pkg::*;
#(
   parameter int           WIDTH       = 4,
   parameter carry_style_e CARRY_STYLE = CARRY_FLOPPED
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [WIDTH-1:0] count_o,
   output logic             carry_o
);
   // R8: elaboration-time width check
   if (WIDTH < int'(min_width())) begin : g_bad_width
      $error("sync_carry_counter: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] cnt_q;
   logic             carry_w;

   sccnt_core #(.WIDTH(WIDTH)) u_core (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .cnt_q_o (cnt_q)
   );

   if (CARRY_STYLE == CARRY_FLOPPED) begin : g_carry_reg
      // R5
      sccnt_carry_reg #(.WIDTH(WIDTH)) u_carry (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .cnt_i   (cnt_q),
         .carry_o (carry_w)
      );
   end else begin : g_carry_dec
      // R6
      sccnt_carry_dec #(.WIDTH(WIDTH)) u_carry (
         .cnt_i   (cnt_q),
         .carry_o (carry_w)
      );
   end

   assign count_o = cnt_q;
   assign carry_o = carry_w;
endmodule

// File: rtl/sync_carry_counter_chk.sv
module sync_carry_counter_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic [WIDTH-1:0] count_o,
   input logic             carry_o
);
   localparam logic [WIDTH-1:0] ALL_ONES = '1;
   localparam logic [WIDTH-1:0] PRE_TERM = {{(WIDTH-1){1'b1}}, 1'b0};

   logic rst_q = 1'b0;
   always_ff @(posedge clk_i) rst_q <= rst_i;

   // R2
   always_ff @(posedge clk_i) begin
      if (rst_q) begin
         reset_clear_chk : assert (count_o == '0 && !carry_o)
            else $error("reset did not clear counter");
      end
   end

   // R1
   count_step_chk : assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> count_o == WIDTH'($past(count_o) + WIDTH'(1)));

   // R3
   carry_match_chk : assert property (@(posedge clk_i) disable iff (rst_i)
      carry_o == (count_o == ALL_ONES));

   // R4
   wrap_chk : assert property (@(posedge clk_i) disable iff (rst_i)
      (count_o == ALL_ONES) |=> (count_o == '0 && !carry_o));

   // R5
   carry_rise_chk : assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(carry_o) |-> $past(count_o) == PRE_TERM);
endmodule

bind sync_carry_counter sync_carry_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .count_o (count_o),
   .carry_o (carry_o)
);

// File: tb/sync_carry_counter_tb.sv
module sync_carry_counter_tb;
   import sccnt_pkg::*;

   localparam int W = 4;

   typedef struct {
      logic         rst;
      logic [W-1:0] cnt;
      logic         cy;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] cnt_f, cnt_d;
   logic         cy_f, cy_d;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   exp_t         sb_q[$];
   logic [W-1:0] model_cnt = '0;

   always #4 clk = ~clk; // 125 MHz

   sync_carry_counter #(.WIDTH(W), .CARRY_STYLE(CARRY_FLOPPED)) u_dut (
      .clk_i(clk), .rst_i(rst), .count_o(cnt_f), .carry_o(cy_f));

   sync_carry_counter #(.WIDTH(W), .CARRY_STYLE(CARRY_DECODED)) u_dut_dec (
      .clk_i(clk), .rst_i(rst), .count_o(cnt_d), .carry_o(cy_d));

   // driver: apply reset value for one edge, push expected result
   task automatic step(input logic r);
      exp_t e;
      @(negedge clk);
      rst = r;
      @(posedge clk);
      #1;
      model_cnt = r ? '0 : model_cnt + 1'b1;
      e.rst = r;
      e.cnt = model_cnt;
      e.cy  = (model_cnt == '1);
      sb_q.push_back(e);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step(1'b0);
   endtask

   task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            exp_t e;
            string ct;
            e = sb_q.pop_front();
            if (e.rst)             ct = "R2";
            else if (e.cnt == '0)  ct = "R4";
            else if (e.cy)         ct = "R3";
            else                   ct = "R1";
            cmp({ct, " count flopped"}, cnt_f, e.cnt);
            cmp({ct, " count decoded"}, cnt_d, e.cnt);
            cmp({ct, " R5 carry flopped"}, W'(cy_f), W'(e.cy));
            cmp({ct, " R6 carry decoded"}, W'(cy_d), W'(e.cy));
            cmp("R7 styles agree", {cnt_f[W-2:0], cy_f}, {cnt_d[W-2:0], cy_d});
         end
      end
   end

   initial begin
      step(1'b1);
      step(1'b1);            // R2 reset state
      run(40);               // R1 R3 R4: more than two wraps
      step(1'b1);            // R2 mid-count reset (count 8)
      run(14);               // reaches 4'b1110
      step(1'b1);            // R5 reset on the carry-load edge
      run(3);
      step(1'b1);
      step(1'b1);
      run(35);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule